// File: doc/BRIEF.md
# Carry-Select Adder with Add-One Converter

This block is a purely combinational two's-complement adder of parameterised width. The operand bits are cut into carry-select groups of configurable, possibly unequal, sizes. The lowest group is a plain ripple-carry adder driven by the external carry-in. Every higher group computes its sum once, with a ripple-carry adder whose carry-in is held at zero. It also prepares the result that a carry-in of one would give. The carry arriving from the group below then picks one of the two results, together with the group's carry-out.

The block can be built in two variants, chosen by a parameter. The regular variant prepares the carry-in-one result with a second ripple-carry adder. The reduced variant derives it from the carry-in-zero result through an add-one converter. The converter is an XOR per bit with a running AND of the lower bits, which is cheaper than a chain of full adders. Both variants give identical results, so they can be compared in area.

A subtractor is obtained at the ports by feeding the inverted second operand and a carry-in of one.

Top module: `csla_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of the unsigned sum `a_i + b_i + cin_i` for every input combination.
- R2: `cout_o` equals bit WIDTH of that same unsigned sum, i.e. it is 1 exactly when the sum reaches 2^WIDTH.
- R3: The carry entering each higher group equals the carry out of the exact sum of all bits below that group, so a carry ripples correctly across any number of group boundaries (e.g. 0xFFFF + 0x0000 + 1 gives sum 0x0000, carry 1).
- R4: In every higher group the prepared carry-in-one result, taken as a group-width-plus-one value, equals the carry-in-zero result plus one. The carry-in-one carry is therefore set whenever the carry-in-zero carry is set, or whenever the carry-in-zero sum is all ones.
- R5: The lowest group uses the external carry-in directly, so with both operands zero `cin_i` = 1 gives sum 1 and carry 0.
- R6: Feeding `b_i` = ~x with `cin_i` = 1 yields `sum_o` = a − x modulo 2^WIDTH, and `cout_o` = 1 exactly when a ≥ x as unsigned values (no borrow).
- R7: The regular variant (KIND = CSLA_DUAL, second ripple adder) and the reduced variant (KIND = CSLA_BEC, add-one converter) produce identical `sum_o` and `cout_o` for the same inputs.
- R8: Group sizes come from the GSIZES parameter, which holds one 8-bit size per group, lowest group in the lowest byte. Any layout whose sizes add up to WIDTH meets R1 and R2; the default for 16 bits is 2,2,3,4,5 from the bottom.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand (inverted by the user for subtraction) |
| cin_i | input | 1 | Carry into the lowest group |
| sum_o | output | WIDTH | Low WIDTH bits of the sum |
| cout_o | output | 1 | Carry out of the highest group |

## Verification
Every result of this block is due in the same cycle as its stimulus, since no register lies between any input and any output. The bench therefore changes the operands just after a rising clock edge. It reads `sum_o` and `cout_o` at the following falling edge, half a period later, when every group's ripple and select path has settled. The internal group carries and the two prepared group results are checked continuously by the bound checker whenever all inputs are known. The same stimulus drives both variants and an 8-bit instance with an uneven group layout.

// File: rtl/csla_pkg.sv
package csla_pkg;

  // Variant of the carry-in-one path in each select group
  typedef enum logic {
    CSLA_DUAL = 1'b0,  // second ripple-carry adder with carry-in tied high
    CSLA_BEC  = 1'b1   // add-one converter on the carry-in-zero result
  } csla_kind_e;

  // Size of group g, read from a byte-packed size list (lowest group first)
  function automatic int grp_size(input logic [255:0] sizes, input int g);
    return int'(sizes[8*g +: 8]);
  endfunction

  // Bit offset of group g: total size of all groups below it
  function automatic int grp_offset(input logic [255:0] sizes, input int g);
    int acc;
    acc = 0;
    for (int k = 0; k < g; k++) acc += int'(sizes[8*k +: 8]);
    return acc;
  endfunction

  // One-bit full adder, sum output
  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  // One-bit full adder, carry output (majority)
  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction

endpackage

// File: rtl/csla_rca.sv
module csla_rca #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] x_i,
  input  logic [GW-1:0] y_i,
  input  logic          c_i,
  output logic [GW-1:0] s_o,
  output logic          c_o
);
  import csla_pkg::*;

  logic [GW:0] chain;

  assign chain[0] = c_i;

  for (genvar i = 0; i < GW; i++) begin : g_bit
    assign s_o[i]       = fa_sum(x_i[i], y_i[i], chain[i]);
    assign chain[i + 1] = fa_carry(x_i[i], y_i[i], chain[i]);
  end

  assign c_o = chain[GW];

endmodule

// File: rtl/csla_bec.sv
module csla_bec #(
  parameter int W = 5
) (
  input  logic [W-1:0] v_i,
  output logic [W-1:0] inc_o
);

  // run[i] is high when every bit below i is one; bit 0 therefore always flips
  logic [W-1:0] run;

  assign run[0] = 1'b1;

  for (genvar i = 1; i < W; i++) begin : g_run
    assign run[i] = run[i - 1] & v_i[i - 1];
  end

  assign inc_o = v_i ^ run;

endmodule

// File: rtl/csla_group.sv
module csla_group #(
  parameter int                   GW   = 4,
  parameter csla_pkg::csla_kind_e KIND = csla_pkg::CSLA_BEC
) (
  input  logic [GW-1:0] x_i,
  input  logic [GW-1:0] y_i,
  input  logic          sel_i,
  output logic [GW-1:0] s0_o,
  output logic          c0_o,
  output logic [GW-1:0] s1_o,
  output logic          c1_o,
  output logic [GW-1:0] s_o,
  output logic          c_o
);

  // Carry-in-zero path, always present
  csla_rca #(.GW(GW)) u_rca0 (
    .x_i (x_i),
    .y_i (y_i),
    .c_i (1'b0),
    .s_o (s0_o),
    .c_o (c0_o)
  );

  // Carry-in-one path, variant picked by KIND
  if (KIND == csla_pkg::CSLA_DUAL) begin : g_dual
    csla_rca #(.GW(GW)) u_rca1 (
      .x_i (x_i),
      .y_i (y_i),
      .c_i (1'b1),
      .s_o (s1_o),
      .c_o (c1_o)
    );
  end else begin : g_bec
    csla_bec #(.W(GW + 1)) u_bec (
      .v_i   ({c0_o, s0_o}),
      .inc_o ({c1_o, s1_o})
    );
  end

  // Select by the real incoming carry
  assign s_o = sel_i ? s1_o : s0_o;
  assign c_o = sel_i ? c1_o : c0_o;

endmodule

// File: rtl/csla_adder.sv
module csla_adder #(
  parameter int                     WIDTH   = 16,
  parameter int                     NGROUPS = 5,
  parameter logic [8*NGROUPS-1:0]   GSIZES  = {8'd5, 8'd4, 8'd3, 8'd2, 8'd2},
  parameter csla_pkg::csla_kind_e   KIND    = csla_pkg::CSLA_BEC
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  import csla_pkg::*;

  localparam logic [255:0] SIZES_W = 256'(GSIZES);

  // Named internal events for the checker
  logic [NGROUPS:0]   grp_cin;  // carry into each group, top entry is the final carry
  logic [NGROUPS-1:0] alt_c0;   // carry-in-zero carry of each group
  logic [NGROUPS-1:0] alt_c1;   // carry-in-one carry of each group
  logic [WIDTH-1:0]   alt_s0;   // carry-in-zero sums, groups side by side
  logic [WIDTH-1:0]   alt_s1;   // carry-in-one sums, groups side by side
  logic [WIDTH-1:0]   sum_w;

  assign grp_cin[0] = cin_i;

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    localparam int OFF = grp_offset(SIZES_W, g);
    localparam int GW  = grp_size(SIZES_W, g);

    if (g == 0) begin : g_low
      // Lowest group: a single ripple adder on the external carry
      logic [GW-1:0] s_low;
      logic          c_low;
      csla_rca #(.GW(GW)) u_rca (
        .x_i (a_i[OFF +: GW]),
        .y_i (b_i[OFF +: GW]),
        .c_i (grp_cin[0]),
        .s_o (s_low),
        .c_o (c_low)
      );
      assign sum_w[OFF +: GW]  = s_low;
      assign alt_s0[OFF +: GW] = s_low;
      assign alt_s1[OFF +: GW] = s_low;
      assign alt_c0[g]         = c_low;
      assign alt_c1[g]         = c_low;
      assign grp_cin[g + 1]    = c_low;
    end else begin : g_sel
      csla_group #(.GW(GW), .KIND(KIND)) u_grp (
        .x_i   (a_i[OFF +: GW]),
        .y_i   (b_i[OFF +: GW]),
        .sel_i (grp_cin[g]),
        .s0_o  (alt_s0[OFF +: GW]),
        .c0_o  (alt_c0[g]),
        .s1_o  (alt_s1[OFF +: GW]),
        .c1_o  (alt_c1[g]),
        .s_o   (sum_w[OFF +: GW]),
        .c_o   (grp_cin[g + 1])
      );
    end
  end

  assign sum_o  = sum_w;
  assign cout_o = grp_cin[NGROUPS];

endmodule

// File: rtl/csla_adder_chk.sv
module csla_adder_chk #(
  parameter int                   WIDTH   = 16,
  parameter int                   NGROUPS = 5,
  parameter logic [8*NGROUPS-1:0] GSIZES  = {8'd5, 8'd4, 8'd3, 8'd2, 8'd2}
) (
  input logic [WIDTH-1:0]   a_i,
  input logic [WIDTH-1:0]   b_i,
  input logic               cin_i,
  input logic [WIDTH-1:0]   sum_o,
  input logic               cout_o,
  input logic [NGROUPS:0]   grp_cin,
  input logic [NGROUPS-1:0] alt_c0,
  input logic [NGROUPS-1:0] alt_c1,
  input logic [WIDTH-1:0]   alt_s0,
  input logic [WIDTH-1:0]   alt_s1
);
  import csla_pkg::*;

  localparam logic [255:0] SIZES_W = 256'(GSIZES);

  logic             known;
  logic [WIDTH:0]   full;

  assign known = !$isunknown({a_i, b_i, cin_i});
  assign full  = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    if (known) begin
      AST_SUM_VALUE: assert (sum_o == full[WIDTH-1:0]) else $error("sum mismatch"); // R1
      AST_CARRY_OUT: assert (cout_o == full[WIDTH]) else $error("carry-out mismatch"); // R2
    end
  end

  for (genvar g = 1; g < NGROUPS; g++) begin : g_chk
    localparam int OFF = grp_offset(SIZES_W, g);
    localparam int GW  = grp_size(SIZES_W, g);
    localparam logic [WIDTH:0] MASK = {(WIDTH + 1){1'b1}} >> (WIDTH + 1 - OFF);

    logic [WIDTH:0] low_part;
    logic [GW:0]    v0;
    logic [GW:0]    v1;

    assign low_part = ({1'b0, a_i} & MASK) + ({1'b0, b_i} & MASK) + {{WIDTH{1'b0}}, cin_i};
    assign v0       = {alt_c0[g], alt_s0[OFF +: GW]};
    assign v1       = {alt_c1[g], alt_s1[OFF +: GW]};

    always_comb begin
      if (known) begin
        AST_GROUP_CARRY_IN: assert (grp_cin[g] == low_part[OFF]) else $error("group carry-in mismatch"); // R3
        AST_ONE_PATH_INC: assert (v1 == v0 + 1'b1) else $error("carry-in-one path is not carry-in-zero plus one"); // R4
        AST_ONE_PATH_ORDER: assert (!alt_c0[g] || alt_c1[g]) else $error("carry-in-one carry lower than carry-in-zero carry"); // R4
      end
    end
  end

endmodule

bind csla_adder csla_adder_chk #(
  .WIDTH   (WIDTH),
  .NGROUPS (NGROUPS),
  .GSIZES  (GSIZES)
) u_csla_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .cin_i   (cin_i),
  .sum_o   (sum_o),
  .cout_o  (cout_o),
  .grp_cin (grp_cin),
  .alt_c0  (alt_c0),
  .alt_c1  (alt_c1),
  .alt_s0  (alt_s0),
  .alt_s1  (alt_s1)
);

// File: tb/tb_csla_adder.sv
module tb_csla_adder;
  import csla_pkg::*;

  localparam int W  = 16;
  localparam int W8 = 8;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         c;
    logic [W:0]   exp;  // {carry, sum}
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0000, 1'b0, 17'h00000},  // R1 zero
    '{16'h0000, 16'h0000, 1'b1, 17'h00001},  // R5 carry-in into lowest group
    '{16'hFFFF, 16'h0001, 1'b0, 17'h10000},  // R2 R3 full ripple
    '{16'hFFFF, 16'h0000, 1'b1, 17'h10000},  // R3 carry from cin through every group
    '{16'h1234, 16'h4321, 1'b0, 17'h05555},  // R1 no carries
    '{16'h8000, 16'h8000, 1'b0, 17'h10000},  // R2 top-group carry only
    '{16'h00FF, 16'h0001, 1'b0, 17'h00100},  // R3 ripple across three boundaries
    '{16'h0003, 16'h0001, 1'b0, 17'h00004},  // R3 first boundary
    '{16'h000F, 16'h0000, 1'b1, 17'h00010},  // R4 all-ones group sum plus carry
    '{16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},  // R2 R4 every group carries both ways
    '{16'h7FFF, 16'h0001, 1'b0, 17'h08000},  // R1 signed wrap to most negative
    '{16'h0005, 16'hFFFC, 1'b1, 17'h10002},  // R6 5 - 3, no borrow
    '{16'h0003, 16'hFFFA, 1'b1, 17'h0FFFE},  // R6 3 - 5, borrow
    '{16'hABCD, 16'h5432, 1'b1, 17'h10000}   // R4 all-ones total plus carry
  };

  logic clk;
  logic rst_n;
  logic [W-1:0]  a, b;
  logic          cin;
  logic [W-1:0]  s_bec, s_dual;
  logic          co_bec, co_dual;
  logic [W8-1:0] a8, b8, s8;
  logic          cin8, co8;

  int checks;
  int errors;

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  csla_adder #(.WIDTH(W), .NGROUPS(5), .GSIZES({8'd5, 8'd4, 8'd3, 8'd2, 8'd2}), .KIND(CSLA_BEC)) dut (
    .a_i (a), .b_i (b), .cin_i (cin), .sum_o (s_bec), .cout_o (co_bec)
  );

  csla_adder #(.WIDTH(W), .NGROUPS(5), .GSIZES({8'd5, 8'd4, 8'd3, 8'd2, 8'd2}), .KIND(CSLA_DUAL)) dut_dual (
    .a_i (a), .b_i (b), .cin_i (cin), .sum_o (s_dual), .cout_o (co_dual)
  );

  // Uneven 8-bit layout: 1,3,4 from the bottom
  csla_adder #(.WIDTH(W8), .NGROUPS(3), .GSIZES({8'd4, 8'd3, 8'd1}), .KIND(CSLA_BEC)) dut_w8 (
    .a_i (a8), .b_i (b8), .cin_i (cin8), .sum_o (s8), .cout_o (co8)
  );

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive after a rising edge, sample at the next falling edge
  task automatic apply16(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
  endtask

  task automatic apply8(input logic [W8-1:0] x, input logic [W8-1:0] y, input logic c);
    @(posedge clk);
    a8 = x; b8 = y; cin8 = c;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0]  lfsr;
    logic [W:0]   ref16;
    logic [W8:0]  ref8;
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    a = '0; b = '0; cin = 1'b0;
    a8 = '0; b8 = '0; cin8 = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state: idle inputs give zero (R1, R2)
    check("R1 reset state sum", {co_bec, s_bec}, '0);

    // Table walk: both variants against the hand-computed result
    for (int i = 0; i < NV; i++) begin
      apply16(VECS[i].a, VECS[i].b, VECS[i].c);
      check($sformatf("R1/R2 vector %0d converter variant", i), {co_bec, s_bec}, VECS[i].exp);
      check($sformatf("R7 vector %0d dual-adder variant", i), {co_dual, s_dual}, VECS[i].exp);
    end

    // R6 directed: equal operands subtract to zero without borrow
    apply16(16'h4A5B, ~16'h4A5B, 1'b1);
    check("R6 x - x", {co_bec, s_bec}, 17'h10000);

    // R5: carry-in alone changes only bit 0
    apply16(16'hFFFE, 16'h0000, 1'b1);
    check("R5 cin sets bit 0", {co_bec, s_bec}, 17'h0FFFF);

    // Pseudo-random sweep against a behavioural sum (R1, R2, R7)
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 300; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      apply16(lfsr[15:0], lfsr[31:16], lfsr[7]);
      ref16 = {1'b0, lfsr[15:0]} + {1'b0, lfsr[31:16]} + {{W{1'b0}}, lfsr[7]};
      check("R1 random converter variant", {co_bec, s_bec}, ref16);
      check("R7 random dual-adder variant", {co_dual, s_dual}, ref16);
    end

    // R8: uneven 8-bit layout
    apply8(8'hFF, 8'h00, 1'b1);
    check("R8 8-bit full ripple", {8'h00, co8, s8}, {8'h00, 9'h100});
    apply8(8'h0E, 8'h01, 1'b1);
    check("R8 8-bit boundary at bit 4", {8'h00, co8, s8}, {8'h00, 9'h010});
    for (int i = 0; i < 200; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      apply8(lfsr[7:0], lfsr[15:8], lfsr[20]);
      ref8 = {1'b0, lfsr[7:0]} + {1'b0, lfsr[15:8]} + {{W8{1'b0}}, lfsr[20]};
      check("R8 8-bit random", {8'h00, co8, s8}, {8'h00, ref8});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule